// File: doc/BRIEF.md
# MII carrier sense and collision generator

This block drives the carrier-sense (CRS) and collision (COL) indications that a media-independent Ethernet interface presents to its MAC. It takes transmit enable from the MAC side and a qualified receive-activity flag from the line side. It also takes configuration levels for duplex, speed, serial 10 Mb/s operation and the carrier-sense source. From these it forms both indications combinationally, with no register stage between the inputs and the pins.

A jabber timer runs on the transmit clock. It measures how long transmit enable has been held high without a break. When the limit is reached, an expired flag is set. The flag is released only after transmit enable has stayed low for an unjab interval. In serial 10 Mb/s half-duplex operation, COL carries this expired flag in place of the collision indication. Both intervals are parameters, expressed in transmit-clock cycles.

Top module: `mii_crs_col`

## Requirements
- R1: In half duplex, when serial 10 Mb/s operation is not selected (`ser_mode`=0 or `spd_100`=1), `col` equals `tx_en & rx_act` in the same cycle, with no clock delay.
- R2: When `full_dup`=1, `col` is 0 regardless of every other input and of the jabber state.
- R3: In half duplex with `ser_mode`=1 and `spd_100`=0, `col` equals the jabber expired flag and does not follow `tx_en & rx_act`.
- R4: With `crs_rx_only`=0, `crs` equals `tx_en | rx_act` in the same cycle, in either duplex. It therefore stays high for as long as a collision lasts.
- R5: With `crs_rx_only`=1, `crs` equals `rx_act` in either duplex, and `tx_en` has no effect on it.
- R6: The expired flag is set by the rising edge on which `tx_en` has been sampled high on `JAB_LIMIT` consecutive edges. A burst of `JAB_LIMIT`-1 high edges followed by a low edge leaves it clear.
- R7: Once set, the expired flag stays set while `tx_en` is high. It clears on the edge that completes `UNJAB_LEN` consecutive low samples of `tx_en`. A high sample during that interval restarts the count.
- R8: A synchronous active-high `rst` clears the jabber count and the expired flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx_act | input | 1 | Qualified receive activity from the line side |
| full_dup | input | 1 | 1 = full duplex |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ser_mode | input | 1 | 1 = serial interface selected |
| crs_rx_only | input | 1 | 1 = carrier sense from receive only |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision, or jabber expired in serial 10 Mb/s |

## Verification
The bench drives every combination of duplex, speed, serial mode and carrier-sense source against random transmit/receive activity. With both activity flags high, the output tells a true collision apart from the forced-low full-duplex case and from the jabber-reporting case. Carrier sense is checked in cycles where only transmit is active, which separates the two source selections. The bench holds transmit enable high in long random runs so that the jabber flag sets and clears during the random phase. Directed cases place transmit bursts and idle gaps exactly one cycle short of each limit and exactly at it. They also break the unjab gap with a single high cycle and apply reset while the flag is set.

// File: rtl/mii_crs_col_pkg.sv
package mii_crs_col_pkg;
  typedef enum logic [1:0] {
    COL_SRC_OFF     = 2'd0,
    COL_SRC_COLLIDE = 2'd1,
    COL_SRC_JABBER  = 2'd2
  } col_src_e;

  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/mii_jabber_timer.sv
module mii_jabber_timer #(
  parameter int unsigned JAB_LIMIT = 50000,
  parameter int unsigned UNJAB_LEN = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  output logic expired
);
  localparam int unsigned CW = mii_crs_col_pkg::cnt_width(JAB_LIMIT, UNJAB_LEN);
  localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_LIMIT - 1);
  localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  // One counter serves both phases: it runs on tx_en high while armed,
  // and on tx_en low while expired.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (!tx_en) begin
        cnt_q <= '0;
      end else if (cnt_q == JAB_LAST) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (tx_en) begin
        cnt_q <= '0;
      end else if (cnt_q == UNJAB_LAST) begin
        cnt_q <= '0;
        exp_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/mii_col_crs_logic.sv
module mii_col_crs_logic
  import mii_crs_col_pkg::*;
(
  input  logic tx_en,
  input  logic rx_act,
  input  logic full_dup,
  input  logic spd_100,
  input  logic ser_mode,
  input  logic crs_rx_only,
  input  logic jab_expired,
  output logic crs,
  output logic col
);
  col_src_e col_src;

  always_comb begin
    if (full_dup)
      col_src = COL_SRC_OFF;
    else if (ser_mode && !spd_100)
      col_src = COL_SRC_JABBER;
    else
      col_src = COL_SRC_COLLIDE;
  end

  always_comb begin
    unique case (col_src)
      COL_SRC_COLLIDE: col = tx_en & rx_act;
      COL_SRC_JABBER:  col = jab_expired;
      default:         col = 1'b0;
    endcase
  end

  assign crs = crs_rx_only ? rx_act : (tx_en | rx_act);
endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col #(
  parameter int unsigned JAB_LIMIT = 50000,
  parameter int unsigned UNJAB_LEN = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic rx_act,
  input  logic full_dup,
  input  logic spd_100,
  input  logic ser_mode,
  input  logic crs_rx_only,
  output logic crs,
  output logic col
);
  logic jab_expired;

  mii_jabber_timer #(
    .JAB_LIMIT(JAB_LIMIT),
    .UNJAB_LEN(UNJAB_LEN)
  ) i_jab (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .expired(jab_expired)
  );

  mii_col_crs_logic i_ind (
    .tx_en      (tx_en),
    .rx_act     (rx_act),
    .full_dup   (full_dup),
    .spd_100    (spd_100),
    .ser_mode   (ser_mode),
    .crs_rx_only(crs_rx_only),
    .jab_expired(jab_expired),
    .crs        (crs),
    .col        (col)
  );
endmodule

// File: rtl/mii_crs_col_chk.sv
module mii_crs_col_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic rx_act,
  input logic full_dup,
  input logic spd_100,
  input logic ser_mode,
  input logic crs_rx_only,
  input logic crs,
  input logic col,
  input logic jab
);
  // R1
  collide_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_dup && (!ser_mode || spd_100) && tx_en && rx_act) |-> col);
  // R2
  fdx_col_low_chk: assert property (@(posedge clk) disable iff (rst)
    full_dup |-> !col);
  // R3
  jab_report_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_dup && ser_mode && !spd_100) |-> (col == jab));
  // R4
  crs_any_chk: assert property (@(posedge clk) disable iff (rst)
    (!crs_rx_only && (tx_en || rx_act)) |-> crs);
  // R5
  crs_rx_chk: assert property (@(posedge clk) disable iff (rst)
    crs_rx_only |-> (crs == rx_act));
  // R6
  jab_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(jab) |-> $past(tx_en));
  // R6
  jab_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!jab && !tx_en) |=> !jab);
  // R7
  jab_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (jab && tx_en) |=> jab);
endmodule

bind mii_crs_col mii_crs_col_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .rx_act     (rx_act),
  .full_dup   (full_dup),
  .spd_100    (spd_100),
  .ser_mode   (ser_mode),
  .crs_rx_only(crs_rx_only),
  .crs        (crs),
  .col        (col),
  .jab        (jab_expired)
);

// File: tb/test_mii_crs_col.sv
module test_mii_crs_col;
  localparam int unsigned JL = 24;
  localparam int unsigned UL = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, rx_act = 1'b0, full_dup = 1'b0, spd_100 = 1'b0;
  logic ser_mode = 1'b0, crs_rx_only = 1'b0;
  logic crs, col;

  int n_cmp = 0;
  int n_bad = 0;
  int run_cnt = 0;
  int idle_cnt = 0;
  bit ref_jab = 1'b0;

  always #2 clk = ~clk;

  mii_crs_col #(.JAB_LIMIT(JL), .UNJAB_LEN(UL)) i_mii_crs_col (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_act(rx_act),
    .full_dup(full_dup), .spd_100(spd_100), .ser_mode(ser_mode),
    .crs_rx_only(crs_rx_only), .crs(crs), .col(col)
  );

  function automatic bit exp_col(bit t, bit r, bit fd, bit s100, bit ser, bit j);
    if (fd) return 1'b0;
    if (ser && !s100) return j;
    return t & r;
  endfunction

  function automatic bit exp_crs(bit t, bit r, bit rxo);
    return rxo ? r : (t | r);
  endfunction

  task automatic check(input bit got, input bit want, input string req);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  function automatic string col_req(bit fd, bit s100, bit ser);
    if (fd) return "R2";
    if (ser && !s100) return "R3";
    return "R1";
  endfunction

  task automatic check_outputs();
    check(col, exp_col(tx_en, rx_act, full_dup, spd_100, ser_mode, ref_jab),
          col_req(full_dup, spd_100, ser_mode));
    check(crs, exp_crs(tx_en, rx_act, crs_rx_only), crs_rx_only ? "R5" : "R4");
  endtask

  // reference jabber model, applied after each rising edge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      ref_jab = 1'b0; run_cnt = 0; idle_cnt = 0;
    end else if (!ref_jab) begin
      run_cnt = tx_en ? run_cnt + 1 : 0;
      if (run_cnt == JL) begin ref_jab = 1'b1; run_cnt = 0; idle_cnt = 0; end
    end else begin
      idle_cnt = tx_en ? 0 : idle_cnt + 1;
      if (idle_cnt == UL) begin ref_jab = 1'b0; idle_cnt = 0; run_cnt = 0; end
    end
    @(negedge clk);
  endtask

  task automatic ser10();
    full_dup = 0; spd_100 = 0; ser_mode = 1; crs_rx_only = 0; rx_act = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); step(); step();
    // R8: outputs quiet in reset
    #1 check(col, 1'b0, "R8"); check(crs, 1'b0, "R8");
    rst = 0;
    step();

    // R6: one short of limit does not set
    ser10();
    tx_en = 1;
    for (int i = 0; i < JL - 1; i++) step();
    #1 check(col, 1'b0, "R6 short burst");
    tx_en = 0; step();
    #1 check(col, 1'b0, "R6 after break");
    // R6: exactly at limit sets
    tx_en = 1;
    for (int i = 0; i < JL - 1; i++) step();
    #1 check(col, 1'b0, "R6 edge-1");
    step();
    #1 check(col, 1'b1, "R6 limit");
    // R3: collision does not show while flag clear? show flag over rx
    rx_act = 1; #1 check(col, 1'b1, "R3 jab with rx");
    // R7: stays while high
    for (int i = 0; i < 5; i++) step();
    #1 check(col, 1'b1, "R7 hold");
    // R7: gap broken one short, restarts
    tx_en = 0; rx_act = 0;
    for (int i = 0; i < UL - 1; i++) step();
    #1 check(col, 1'b1, "R7 gap-1");
    tx_en = 1; step();
    tx_en = 0;
    for (int i = 0; i < UL - 1; i++) step();
    #1 check(col, 1'b1, "R7 restarted");
    step();
    #1 check(col, 1'b0, "R7 cleared");
    // R8: reset clears a set flag
    tx_en = 1;
    for (int i = 0; i < JL; i++) step();
    #1 check(col, 1'b1, "R8 preset");
    rst = 1; step(); rst = 0; tx_en = 0;
    #1 check(col, 1'b0, "R8 cleared");
    step();
    // R3: collision pattern hidden in serial 10
    tx_en = 1; rx_act = 1; #1 check(col, 1'b0, "R3 no collide");
    // R1: serial at 100 collides
    spd_100 = 1; #1 check(col, 1'b1, "R1 ser100");
    // R2
    full_dup = 1; #1 check(col, 1'b0, "R2 fdx");
    // R5: tx only ignored
    rx_act = 0; crs_rx_only = 1; #1 check(crs, 1'b0, "R5 tx ignored");
    crs_rx_only = 0; #1 check(crs, 1'b1, "R4 tx only");
    tx_en = 0; step(); step();

    // random phase with long tx runs
    for (int blk = 0; blk < 400; blk++) begin
      int len;
      bit t;
      full_dup    = ($urandom % 4) == 0;
      spd_100     = $urandom % 2;
      ser_mode    = $urandom % 2;
      crs_rx_only = $urandom % 2;
      t   = $urandom % 2;
      len = t ? ($urandom % (2 * JL)) + 1 : ($urandom % (2 * UL)) + 1;
      for (int i = 0; i < len; i++) begin
        tx_en  = t;
        rx_act = $urandom % 2;
        #1 check_outputs();
        step();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule